// File: doc/BRIEF.md
# Card Interrupt Signalling Gate

This block decides, one clock at a time, whether an I/O card may drive a pending function interrupt onto its interrupt line. A function interrupt is a candidate when its pending flag and its enable flag are both set and the card-wide interrupt master enable is on. The gate then checks whether the current bus situation allows the line to be driven.

In SPI mode the line may normally be driven only while the card is selected. A card that has the continuous-interrupt capability, with that feature switched on, may drive it at any time. This setting covers every function on the card together. In 4-bit SD mode, a multi-block transfer normally holds a pending interrupt back until the transfer ends. A card with the between-block capability may instead raise it inside the gap between blocks.

The gate stores no interrupt of its own. The pending flags stay set in the functions, so a held interrupt appears in the first permitted cycle after the blocking condition clears. It is neither lost nor repeated. The DAT-line driver, the timing of the interrupt period inside a gap and the register bank are built elsewhere.

Top module: `card_irq_gate`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `irq_out` is 0.
- R2: `irq_out` is 1 only if, at the previous clock edge, `master_en` was 1 and for some function i both `irq_pend[i]` and `irq_en[i]` were 1. Otherwise it is 0, whatever the mode.
- R3: Mode encoding 2'b00 is SPI. In SPI mode without continuous interrupts enabled, a candidate is driven only when `cs_active` is 1.
- R4: In SPI mode with `cont_cap`=1 and `cont_en`=1, a candidate is driven whatever the level of `cs_active`.
- R5: When `cont_cap` is 0, `cont_en` has no effect. In SPI mode with `cs_active`=0 the output stays 0.
- R6: Mode encoding 2'b10 is SD 4-bit. A transfer is running when `xfer_active`=1 and `xfer_done`=0. With `gap_cap`=0 and a transfer running, the output stays 0, even when `blk_gap`=1.
- R7: In SD 4-bit mode with `gap_cap`=1 and a transfer running, a candidate is driven when `blk_gap`=1 and held when `blk_gap`=0.
- R8: In SD 4-bit mode with no transfer running, a candidate is driven in every cycle. A held candidate is driven in the first cycle after the transfer ends.
- R9: Mode encoding 2'b01 is SD 1-bit. In this mode a candidate is always driven, and the transfer status inputs have no effect.
- R10: The output is registered. A change at the inputs shows at `irq_out` only after the next rising clock edge.
- R11: Mode encoding 2'b11 is reserved. In this mode the output is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pend | input | NFUNC | Per-function interrupt pending flags |
| irq_en | input | NFUNC | Per-function interrupt enable flags |
| master_en | input | 1 | Card-wide interrupt master enable |
| mode | input | 2 | Bus mode: 00 SPI, 01 SD 1-bit, 10 SD 4-bit, 11 reserved |
| cs_active | input | 1 | SPI chip select is asserted |
| cont_cap | input | 1 | Card can interrupt in SPI mode regardless of chip select |
| cont_en | input | 1 | Continuous SPI interrupt switched on |
| gap_cap | input | 1 | Card can interrupt between blocks of a 4-bit multi-block transfer |
| xfer_active | input | 1 | A multi-block data transfer is in progress |
| blk_gap | input | 1 | Bus is in the gap between two blocks |
| xfer_done | input | 1 | Transfer has completed |
| irq_out | output | 1 | Registered request to drive the interrupt line |

## Verification
The assertions assume that every input is synchronous to `clk` and holds a settled value at each rising edge. They compare the output with the inputs one edge back. The stimulus changes inputs only on the falling edge. Random cases draw every mode, including the reserved code, together with arbitrary capability, enable and transfer-status combinations, so even unusual pairings such as `blk_gap` without a transfer are legal and covered. Directed sequences hold a candidate across a transfer and release it to exercise the first-permitted-cycle behaviour.

// File: rtl/card_irq_pkg.sv
package card_irq_pkg;
   typedef enum logic [1:0] {
      BUS_SPI  = 2'b00,
      BUS_SD1  = 2'b01,
      BUS_SD4  = 2'b10,
      BUS_RSVD = 2'b11
   } bus_mode_e;

   localparam int unsigned MAX_FUNCS = 8;
endpackage

// File: rtl/irq_candidate.sv
module irq_candidate #(
   parameter int unsigned NFUNC = 7
) (
   input  logic [NFUNC-1:0] pend,
   input  logic [NFUNC-1:0] en,
   input  logic             master_en,
   output logic             any_ready
);
   logic [NFUNC-1:0] armed;

   genvar gi;
   generate
      for (gi = 0; gi < NFUNC; gi++) begin : g_fn
         assign armed[gi] = pend[gi] & en[gi];
      end
      if (NFUNC == 1) begin : g_single
         assign any_ready = master_en & armed[0];
      end else begin : g_multi
         assign any_ready = master_en & (|armed);
      end
   endgenerate
endmodule

// File: rtl/spi_permit.sv
module spi_permit (
   input  logic cs_active,
   input  logic cont_cap,
   input  logic cont_en,
   output logic permit
);
   logic continuous;
   // the enable is only writable when the capability exists
   assign continuous = cont_cap & cont_en;
   assign permit     = cs_active | continuous;
endmodule

// File: rtl/sd_permit.sv
module sd_permit #(
   parameter bit GAP_BUILT = 1'b1
) (
   input  logic wide_bus,
   input  logic xfer_active,
   input  logic blk_gap,
   input  logic xfer_done,
   input  logic gap_cap,
   output logic permit
);
   logic running;
   logic gap_ok;

   assign running = xfer_active & ~xfer_done;

   generate
      if (GAP_BUILT) begin : g_gap
         assign gap_ok = gap_cap & blk_gap;
      end else begin : g_nogap
         logic unused_gap;
         assign unused_gap = gap_cap ^ blk_gap;
         assign gap_ok     = 1'b0;
      end
   endgenerate

   // a narrow bus has its own interrupt period, so a transfer does not hold it
   assign permit = ~wide_bus | ~running | gap_ok;
endmodule

// File: rtl/card_irq_gate.sv
module card_irq_gate
   import card_irq_pkg::*;
#(
   parameter int unsigned NFUNC     = 7,
   parameter bit          GAP_BUILT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFUNC-1:0] irq_pend,
   input  logic [NFUNC-1:0] irq_en,
   input  logic             master_en,
   input  logic [1:0]       mode,
   input  logic             cs_active,
   input  logic             cont_cap,
   input  logic             cont_en,
   input  logic             gap_cap,
   input  logic             xfer_active,
   input  logic             blk_gap,
   input  logic             xfer_done,
   output logic             irq_out
);
   generate
      if (NFUNC < 1 || NFUNC > MAX_FUNCS) begin : g_bad_nfunc
         $error("card_irq_gate: NFUNC out of range");
      end
   endgenerate

   bus_mode_e bmode;
   logic      any_ready;
   logic      spi_ok;
   logic      sd_ok;
   logic      permit;

   assign bmode = bus_mode_e'(mode);

   irq_candidate #(.NFUNC(NFUNC)) u_cand (
      .pend      (irq_pend),
      .en        (irq_en),
      .master_en (master_en),
      .any_ready (any_ready)
   );

   spi_permit u_spi (
      .cs_active (cs_active),
      .cont_cap  (cont_cap),
      .cont_en   (cont_en),
      .permit    (spi_ok)
   );

   sd_permit #(.GAP_BUILT(GAP_BUILT)) u_sd (
      .wide_bus    (bmode == BUS_SD4),
      .xfer_active (xfer_active),
      .blk_gap     (blk_gap),
      .xfer_done   (xfer_done),
      .gap_cap     (gap_cap),
      .permit      (sd_ok)
   );

   always_comb begin
      unique case (bmode)
         BUS_SPI:  permit = spi_ok;
         BUS_SD1,
         BUS_SD4:  permit = sd_ok;
         default:  permit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_out <= 1'b0;
      else        irq_out <= any_ready & permit;
   end

   // R2
   no_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(any_ready) |-> !irq_out);

   // R3
   spi_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == 2'b00 && !($past(cont_cap) && $past(cont_en)) && irq_out)
      |-> $past(cs_active));

   // R4
   spi_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == 2'b00 && $past(cont_cap) && $past(cont_en) && $past(any_ready))
      |-> irq_out);

   // R6
   hold_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == 2'b10 && $past(xfer_active) && !$past(xfer_done) && !$past(gap_cap))
      |-> !irq_out);

   // R11
   rsvd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == 2'b11) |-> !irq_out);
endmodule

// File: tb/tb_card_irq_gate.sv
`timescale 1ns/1ps
module tb_card_irq_gate;
   localparam int NF = 7;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NF-1:0] irq_pend, irq_en;
   logic          master_en, cs_active, cont_cap, cont_en, gap_cap;
   logic          xfer_active, blk_gap, xfer_done;
   logic [1:0]    mode;
   logic          irq_out;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   card_irq_gate #(.NFUNC(NF)) dut (
      .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_en(irq_en),
      .master_en(master_en), .mode(mode), .cs_active(cs_active),
      .cont_cap(cont_cap), .cont_en(cont_en), .gap_cap(gap_cap),
      .xfer_active(xfer_active), .blk_gap(blk_gap), .xfer_done(xfer_done),
      .irq_out(irq_out)
   );

   function automatic bit model_out();
      bit cand;
      bit ok;
      cand = master_en && ((irq_pend & irq_en) != '0);
      case (mode)
         2'b00:   ok = cs_active || (cont_cap && cont_en);
         2'b01:   ok = 1'b1;
         2'b10:   ok = !(xfer_active && !xfer_done) || (gap_cap && blk_gap);
         default: ok = 1'b0;
      endcase
      return cand && ok;
   endfunction

   function automatic string model_tag();
      if (!(master_en && ((irq_pend & irq_en) != '0))) return "R2";
      case (mode)
         2'b00:   return (cont_cap && cont_en) ? "R4" : "R3";
         2'b01:   return "R9";
         2'b10:   return (xfer_active && !xfer_done) ? (gap_cap ? "R7" : "R6") : "R8";
         default: return "R11";
      endcase
   endfunction

   task automatic chk(input bit act, input bit exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: irq_out=%0b expected=%0b", tag, act, exp);
      end
   endtask

   // inputs already set after a falling edge; sample after the next rising edge
   task automatic step_chk(input string tag);
      bit e;
      e = model_out();
      @(posedge clk);
      @(negedge clk);
      chk(irq_out, e, tag);
   endtask

   task automatic quiet();
      irq_pend = '0; irq_en = '0; master_en = 0; mode = 2'b00;
      cs_active = 0; cont_cap = 0; cont_en = 0; gap_cap = 0;
      xfer_active = 0; blk_gap = 0; xfer_done = 0;
   endtask

   task automatic arm();
      irq_pend = 7'b0000100; irq_en = 7'b0000100; master_en = 1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, irq_out=%0b expected=end", irq_out);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      bit held;
      void'($urandom(32'd1234));
      quiet();
      arm();
      mode  = 2'b01;
      rst_n = 0;
      repeat (3) @(negedge clk);
      chk(irq_out, 1'b0, "R1 during reset");
      rst_n = 1;
      quiet();
      step_chk("R1 after release");

      // R2: pending without enable, enable without master
      mode = 2'b01; irq_pend = 7'b1010101; irq_en = 7'b0101010; master_en = 1;
      step_chk("R2 disjoint pend/en");
      irq_en = 7'b0000001; master_en = 0;
      step_chk("R2 master off");
      master_en = 1;
      step_chk("R2 one function armed");

      // R10: change lands only after the edge
      irq_pend = '0;
      #1;
      chk(irq_out, 1'b1, "R10 before edge");
      step_chk("R10 after edge");

      // R3 / R4 / R5 in SPI mode
      quiet(); arm(); mode = 2'b00;
      cs_active = 0;
      step_chk("R3 cs low");
      cs_active = 1;
      step_chk("R3 cs high");
      cs_active = 0; cont_cap = 1; cont_en = 1;
      step_chk("R4 continuous cs low");
      cont_cap = 0; cont_en = 1;
      step_chk("R5 enable without capability");
      cont_cap = 1; cont_en = 0;
      step_chk("R3 capability without enable");

      // R9: 1-bit mode ignores transfer state
      quiet(); arm(); mode = 2'b01; xfer_active = 1;
      step_chk("R9 transfer running");

      // R6 then release via R8
      quiet(); arm(); mode = 2'b10; xfer_active = 1; gap_cap = 0;
      step_chk("R6 running");
      blk_gap = 1;
      step_chk("R6 gap without capability");
      blk_gap = 0; xfer_done = 1;
      step_chk("R8 first cycle after done");
      xfer_active = 0; xfer_done = 0;
      step_chk("R8 idle bus");

      // R7: gap capability
      xfer_active = 1; gap_cap = 1; blk_gap = 0;
      step_chk("R7 outside gap");
      blk_gap = 1;
      step_chk("R7 in gap");

      // R11: reserved mode
      quiet(); arm(); mode = 2'b11; cs_active = 1;
      step_chk("R11 reserved");

      // random mix
      for (int i = 0; i < 3000; i++) begin
         irq_pend    = NF'($urandom);
         irq_en      = NF'($urandom);
         master_en   = ($urandom % 8) != 0;
         mode        = 2'($urandom);
         cs_active   = 1'($urandom);
         cont_cap    = 1'($urandom);
         cont_en     = 1'($urandom);
         gap_cap     = 1'($urandom);
         xfer_active = 1'($urandom);
         blk_gap     = 1'($urandom);
         xfer_done   = ($urandom % 4) == 0;
         step_chk({"random ", model_tag()});
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule